// File: doc/BRIEF.md
# Write Completion Status Responder

This block decides what byte a nonvolatile memory places on its data pins when the host reads it. While the write controller reports an internal programming period as running, every read turns into a status poll: the returned byte carries two independent progress indicators instead of stored contents. A host may use either indicator, and may begin polling at any moment of the programming period. Once the busy flag drops, reads again return the word supplied by the storage array.

The two indicators sit in the two top bits of the byte. The most significant bit reads back as the complement of the same bit of the byte most recently written. The bit just below it comes from a toggle register that changes state each time a read finishes while programming is under way. The remaining low bits pass the last written byte through unchanged. When busy clears, the toggle register keeps its value. It resumes counting from that value in the next programming period. The array, the write sequencing and the pin drivers are handled by neighbouring blocks.

Top module: `wrp_status_responder`

## Requirements
- R1: After reset the toggle register holds 0, so a poll made before any read has completed returns 0 in bit DATA_W-2.
- R2: While `prog_busy_i` is 0, `rd_data_o` equals `array_data_i` on every bit, in the same cycle.
- R3: While `prog_busy_i` is 1, bit DATA_W-1 of `rd_data_o` is the complement of bit DATA_W-1 of `last_wr_byte_i`, in the same cycle.
- R4: While `prog_busy_i` is 1, bits DATA_W-3 down to 0 of `rd_data_o` equal the same bits of `last_wr_byte_i`.
- R5: A read completes at the clock edge where `rd_strobe_i` is sampled 0 after being sampled 1 at the previous edge. If `prog_busy_i` is 1 at that edge, bit DATA_W-2 of the poll word inverts from the next cycle on. It does not change while the strobe is held high.
- R6: A read that completes while `prog_busy_i` is 0 leaves the toggle register unchanged. This is seen in the first poll of the next programming period.
- R7: The toggle register is not cleared when busy rises or falls. The first poll of a programming period returns the value left by the previous period, so polling may begin at any point.
- R8: In cycles without a completed read, the toggle register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_busy_i | input | 1 | Internal programming period in progress |
| last_wr_byte_i | input | DATA_W | Byte most recently accepted for writing |
| rd_strobe_i | input | 1 | Read access in progress (high for the length of a read) |
| array_data_i | input | DATA_W | Word read from the storage array |
| rd_data_o | output | DATA_W | Byte to drive on the data pins |

## Verification
The data output is a combinational selection. The complemented top bit, the pass-through low bits and the idle array data are therefore due in the same cycle their inputs change. The bench sets inputs on the falling edge and compares one nanosecond later, before the next rising edge. A read is recognised at the first rising edge that samples the strobe low after it was high, so a toggle flip is due one cycle after the strobe is dropped. The behavioural model in the bench advances its toggle state only at rising edges, from the strobe it drove itself one cycle earlier and the current one. It compares the whole output word in every cycle.

// File: rtl/wrp_pkg.sv
package wrp_pkg;

  // Bit position of the complemented status indicator.
  function automatic int unsigned poll_msb_pos(input int unsigned width);
    return width - 1;
  endfunction

  // Bit position of the per-read toggling indicator.
  function automatic int unsigned toggle_pos(input int unsigned width);
    return width - 2;
  endfunction

endpackage

// File: rtl/wrp_read_edge.sv
module wrp_read_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic busy_i,
  output logic advance_o
);

  logic strobe_q;
  logic read_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_i;
  end

  // A read is finished when the strobe goes from high to low.
  assign read_done = strobe_q & ~strobe_i;
  assign advance_o = read_done & busy_i;

  assert_adv_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    advance_o |-> busy_i);

  assert_adv_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    advance_o |-> (!strobe_i && $past(strobe_i)));

endmodule

// File: rtl/wrp_toggle_reg.sv
module wrp_toggle_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic advance_i,
  output logic toggle_o
);

  logic toggle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         toggle_q <= 1'b0;
    else if (advance_i) toggle_q <= ~toggle_q;
  end

  assign toggle_o = toggle_q;

  assert_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i |=> (toggle_o != $past(toggle_o)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_i |=> $stable(toggle_o));

endmodule

// File: rtl/wrp_status_mux.sv
module wrp_status_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] last_byte_i,
  input  logic              toggle_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] data_o
);
  import wrp_pkg::*;

  localparam int unsigned MSB_POS = poll_msb_pos(DATA_W);
  localparam int unsigned TOG_POS = toggle_pos(DATA_W);

  // Status word returned while programming runs.
  function automatic logic [DATA_W-1:0] poll_word(
    input logic [DATA_W-1:0] last,
    input logic              tog
  );
    logic [DATA_W-1:0] w;
    w          = last;
    w[MSB_POS] = ~last[MSB_POS];
    w[TOG_POS] = tog;
    return w;
  endfunction

  logic [DATA_W-1:0] status_word;

  assign status_word = poll_word(last_byte_i, toggle_i);
  assign data_o      = busy_i ? status_word : array_i;

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (data_o == array_i));

  assert_poll_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (data_o[MSB_POS] != last_byte_i[MSB_POS]));

  assert_low_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (data_o[TOG_POS-1:0] == last_byte_i[TOG_POS-1:0]));

endmodule

// File: rtl/wrp_status_responder.sv
module wrp_status_responder #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_busy_i,
  input  logic [DATA_W-1:0] last_wr_byte_i,
  input  logic              rd_strobe_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  import wrp_pkg::*;

  localparam int unsigned TOG_POS = toggle_pos(DATA_W);

  // Internal events named for the assertions.
  logic read_advance;
  logic toggle_bit;

  wrp_read_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_i  (rd_strobe_i),
    .busy_i    (prog_busy_i),
    .advance_o (read_advance)
  );

  wrp_toggle_reg u_toggle (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance_i (read_advance),
    .toggle_o  (toggle_bit)
  );

  wrp_status_mux #(.DATA_W(DATA_W)) u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (prog_busy_i),
    .last_byte_i (last_wr_byte_i),
    .toggle_i    (toggle_bit),
    .array_i     (array_data_i),
    .data_o      (rd_data_o)
  );

  // The toggle bit seen by the host is frozen while the strobe stays high.
  assert_stable_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy_i && rd_strobe_i && $past(prog_busy_i)) |->
      (rd_data_o[TOG_POS] == $past(rd_data_o[TOG_POS])) || $past(read_advance));

  // Idle completed reads leave the toggle state alone.
  assert_idle_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_busy_i |=> $stable(toggle_bit));

endmodule

// File: tb/sim_wrp_status_responder.sv
`timescale 1ns/1ps
module sim_wrp_status_responder;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         busy = 1'b0;
  logic [W-1:0] last = '0;
  logic         strobe = 1'b0;
  logic [W-1:0] arr = '0;
  logic [W-1:0] dout;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Behavioural model state.
  int m_tog = 0;
  int m_prev_strobe = 0;

  always #2.5 clk = ~clk;

  wrp_status_responder #(.DATA_W(W)) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .prog_busy_i    (busy),
    .last_wr_byte_i (last),
    .rd_strobe_i    (strobe),
    .array_data_i   (arr),
    .rd_data_o      (dout)
  );

  function automatic logic [W-1:0] expect_word();
    int v;
    if (!busy) return arr;
    v = int'(last) % 64;
    if (last[7] == 1'b0) v = v + 128;
    if (m_tog != 0) v = v + 64;
    return W'(v);
  endfunction

  task automatic step(input logic b, input logic [W-1:0] lb,
                      input logic [W-1:0] ad, input logic s, input string tag);
    logic [W-1:0] e;
    @(negedge clk);
    busy = b; last = lb; arr = ad; strobe = s;
    #1;
    e = expect_word();
    n_cmp++;
    if (dout !== e) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, dout, e, $time);
    end
    @(posedge clk);
    if (!rst_n) m_prev_strobe = 0;
    else begin
      if (m_prev_strobe == 1 && s == 1'b0 && b == 1'b1) m_tog = 1 - m_tog;
      m_prev_strobe = (s == 1'b1) ? 1 : 0;
    end
  endtask

  task automatic read_pulse(input logic b, input logic [W-1:0] lb,
                            input logic [W-1:0] ad, input int hold, input string tag);
    for (int i = 0; i < hold; i++) step(b, lb, ad, 1'b1, tag);
    step(b, lb, ad, 1'b0, tag);
  endtask

  initial begin
    // R1: reset state seen through a poll during reset
    step(1'b1, 8'h5A, 8'h00, 1'b0, "R1");
    step(1'b1, 8'h5A, 8'h00, 1'b1, "R1");
    step(1'b1, 8'h5A, 8'h00, 1'b0, "R1");
    rst_n = 1'b1;
    step(1'b1, 8'h5A, 8'h11, 1'b0, "R1");
    // R2: idle reads return array data
    read_pulse(1'b0, 8'hFF, 8'hA5, 1, "R2");
    read_pulse(1'b0, 8'h00, 8'h3C, 2, "R2");
    step(1'b0, 8'h80, 8'hC3, 1'b0, "R2");
    // R3/R4/R5: polls while busy with several written bytes
    read_pulse(1'b1, 8'h80, 8'h00, 1, "R3");
    read_pulse(1'b1, 8'h7F, 8'hFF, 3, "R4");
    read_pulse(1'b1, 8'hC0, 8'h12, 1, "R5");
    read_pulse(1'b1, 8'h3F, 8'h12, 2, "R5");
    // R8: long stretch without a completed read
    for (int i = 0; i < 6; i++) step(1'b1, 8'h96, 8'h00, 1'b0, "R8");
    // R5: strobe held high across many cycles
    read_pulse(1'b1, 8'h96, 8'h00, 7, "R5");
    // R6: reads completing while idle leave the toggle alone
    read_pulse(1'b0, 8'h96, 8'h5E, 1, "R6");
    read_pulse(1'b0, 8'h96, 8'h6D, 1, "R6");
    read_pulse(1'b0, 8'h96, 8'h7C, 1, "R6");
    // R7: new programming period resumes from frozen value
    step(1'b1, 8'h21, 8'h00, 1'b0, "R7");
    read_pulse(1'b1, 8'h21, 8'h00, 1, "R7");
    // Busy drops mid-read: completion while idle does not flip (R6)
    step(1'b1, 8'hE4, 8'h00, 1'b1, "R6");
    step(1'b0, 8'hE4, 8'h99, 1'b0, "R6");
    step(1'b1, 8'hE4, 8'h99, 1'b0, "R7");
    // Busy rises mid-read: completion while busy flips (R5)
    step(1'b0, 8'h0F, 8'h44, 1'b1, "R5");
    step(1'b1, 8'h0F, 8'h44, 1'b0, "R5");
    step(1'b1, 8'h0F, 8'h44, 1'b0, "R5");
    // Back-to-back single-cycle reads
    for (int i = 0; i < 8; i++) read_pulse(1'b1, W'(i * 37), 8'h00, 1, "R5");
    step(1'b0, 8'h00, 8'hEE, 1'b0, "R2");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule